// File: doc/BRIEF.md
# Translation Cache With Global Entries

This block keeps a small, fully associative set of finished page translations so that most memory accesses skip the two-level table walk. Each slot holds a 20-bit virtual page number as its tag, a 20-bit physical frame number, and four attribute flags: write-enable, user-access, dirty and global. A lookup takes a 32-bit linear address together with the access kind (user or supervisor, read or write). In the same cycle it returns a hit flag, a permission-fault flag and, on a hit, the physical address.

A fill port loads a slot once the external walker has finished. A strobe marks a write of the directory base register. That write drops every slot not flagged global, and the drop already applies to lookups in the same cycle. A separate full-flush strobe drops every slot, global ones included. A single-page invalidate drops only the slot whose tag equals a given page number.

A write that hits a slot whose dirty flag is clear is reported as a miss. This sends the access back to the walker, which marks the page dirty in memory and then refills the slot.

Top module: `xlat_cache`

## Requirements
- R1: The tag is bits 31:12 of the lookup address. On a hit, lk_paddr equals {frame, lk_addr[11:0]}. When lk_hit is 0, lk_paddr is zero.
- R2: A lookup is combinational, and its outputs settle within the cycle its inputs are applied. A filled slot first answers lookups after the next rising clock edge.
- R3: A fill whose page number already sits in a valid slot overwrites that slot. Otherwise the lowest-numbered invalid slot is used. When all slots are valid, a victim pointer picks the slot. The pointer starts at 0 and advances by one, wrapping, only on fills that evict a valid slot.
- R4: A user access (lk_user=1) faults if the slot's user flag is 0. A user write also faults if the slot's write flag is 0. A fault sets lk_fault=1 and forces lk_hit=0.
- R5: A supervisor access (lk_user=0) never faults. It ignores both the write flag and the user flag.
- R6: A write that matches a slot with no fault and a clear dirty flag gives lk_hit=0 and lk_fault=0. A read of the same slot hits.
- R7: While base_wr is 1, slots with global=0 already miss. From the next edge on they stay invalid, while global slots keep hitting. A fill in that cycle is dropped.
- R8: While flush_all is 1, every lookup misses. From the next edge on, every slot is invalid. A fill in that cycle is dropped.
- R9: inval_en drops, at the next edge, only the slot whose tag equals inval_vpn. Other slots are unaffected.
- R10: After reset, every slot is invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_user | input | 1 | 1 = user access, 0 = supervisor |
| lk_write | input | 1 | 1 = write access |
| lk_hit | output | 1 | Usable translation found |
| lk_fault | output | 1 | Matching slot denies the access |
| lk_paddr | output | 32 | Physical address when lk_hit is 1, else zero |
| fill_en | input | 1 | Load a slot at the next edge |
| fill_vpn | input | 20 | Page number to load |
| fill_pfn | input | 20 | Frame number to load |
| fill_rw | input | 1 | Write permitted to user code |
| fill_us | input | 1 | User access permitted |
| fill_dirty | input | 1 | Page already marked dirty |
| fill_global | input | 1 | Slot survives a directory base write |
| base_wr | input | 1 | Directory base register is written this cycle |
| flush_all | input | 1 | Drop every slot |
| inval_en | input | 1 | Drop the slot tagged inval_vpn |
| inval_vpn | input | 20 | Page number to drop |

## Verification
A stale or missing valid bit shows up at the next lookup of that page as a wrong hit or miss, so every slot is probed after each fill, eviction, invalidate and flush. A wrong victim pointer only shows on the next full-cache fill, as the wrong page disappearing, so eviction order is followed over several evictions with an overwrite fill in between. A corrupted frame or flag shows in the same cycle as a wrong physical address, fault or dirty miss. Sweeping every stored slot over all four access kinds exposes it.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N = 8,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  localparam int AW = VPN_W + OFF_W,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    lk_addr,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [AW-1:0]    lk_paddr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_pfn,
  input  logic             fill_rw,
  input  logic             fill_us,
  input  logic             fill_dirty,
  input  logic             fill_global,
  input  logic             base_wr,
  input  logic             flush_all,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_vpn
);

  logic [N-1:0] vld, rw, us, dty, glb;
  logic [VPN_W-1:0] tag [N];
  logic [VPN_W-1:0] pfn [N];
  logic [IW-1:0] ptr;

  logic [N-1:0] mvec, dupv, invv, keep;
  wire [VPN_W-1:0] lvpn = lk_addr[AW-1:OFF_W];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign keep[i] = !flush_all && !(base_wr && !glb[i]);
    assign mvec[i] = vld[i] && keep[i] && tag[i] == lvpn;
    assign dupv[i] = vld[i] && tag[i] == fill_vpn;
    assign invv[i] = inval_en && vld[i] && tag[i] == inval_vpn;
  end

  logic [VPN_W-1:0] s_pfn;
  logic s_rw, s_us, s_d;
  always_comb begin
    s_pfn = '0; s_rw = 1'b0; s_us = 1'b0; s_d = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (mvec[i]) begin
        s_pfn = s_pfn | pfn[i];
        s_rw  = s_rw | rw[i];
        s_us  = s_us | us[i];
        s_d   = s_d | dty[i];
      end
    end
  end

  wire any  = |mvec;
  wire deny = lk_user && (!s_us || (lk_write && !s_rw));
  assign lk_fault = any && deny;
  assign lk_hit   = any && !deny && !(lk_write && !s_d);
  assign lk_paddr = lk_hit ? {s_pfn, lk_addr[OFF_W-1:0]} : '0;

  logic [IW-1:0] slot;
  logic evict;
  always_comb begin
    slot  = ptr;
    evict = 1'b1;
    if (|dupv) begin
      evict = 1'b0;
      for (int i = 0; i < N; i++) if (dupv[i]) slot = IW'(i);
    end else if (!(&vld)) begin
      evict = 1'b0;
      for (int i = N - 1; i >= 0; i--) if (!vld[i]) slot = IW'(i);
    end
  end

  wire fill_ok = fill_en && !flush_all && !base_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      vld <= vld & keep & ~invv;
      if (fill_ok) begin
        vld[slot] <= 1'b1;
        tag[slot] <= fill_vpn;
        pfn[slot] <= fill_pfn;
        rw[slot]  <= fill_rw;
        us[slot]  <= fill_us;
        dty[slot] <= fill_dirty;
        glb[slot] <= fill_global;
        if (evict) ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

endmodule

module xlat_cache_chk #(
  parameter int N = 8,
  parameter int AW = 32,
  parameter int OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_user,
  input logic          lk_hit,
  input logic          lk_fault,
  input logic [AW-1:0] lk_addr,
  input logic [AW-1:0] lk_paddr,
  input logic          flush_all,
  input logic [N-1:0]  mvec
);
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_addr[OFF_W-1:0]); // R1
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault)); // R4
  AST_SUP_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_user |-> !lk_fault); // R5
  AST_FLUSH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> !lk_hit && !lk_fault); // R8
  AST_FLUSH_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> mvec == '0); // R8
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mvec)); // R3
endmodule

bind xlat_cache xlat_cache_chk #(.N(N), .AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_user(lk_user), .lk_hit(lk_hit),
  .lk_fault(lk_fault), .lk_addr(lk_addr), .lk_paddr(lk_paddr),
  .flush_all(flush_all), .mvec(mvec)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_user = 0, lk_write = 0;
  logic lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic fill_en = 0, fill_rw = 0, fill_us = 0, fill_dirty = 0, fill_global = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0, inval_vpn = '0;
  logic base_wr = 0, flush_all = 0, inval_en = 0;

  int total = 0, bad = 0;
  bit m_v[8], m_rw[8], m_us[8], m_d[8], m_g[8];
  logic [19:0] m_vpn[8], m_pfn[8];
  int m_ptr = 0;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  task automatic look(input string r, input logic [31:0] a, input bit user,
                      input bit wr, input bit mb, input bit ma);
    bit eh, ef; logic [31:0] ep; int s;
    lk_addr = a; lk_user = user; lk_write = wr;
    #2;
    s = -1;
    for (int j = 0; j < 8; j++)
      if (m_v[j] && m_vpn[j] == a[31:12] && !ma && !(mb && !m_g[j])) s = j;
    eh = 0; ef = 0; ep = '0;
    if (s >= 0) begin
      ef = user && (!m_us[s] || (wr && !m_rw[s]));
      eh = !ef && !(wr && !m_d[s]);
      if (eh) ep = {m_pfn[s], a[11:0]};
    end
    total++;
    if ({lk_hit, lk_fault, lk_paddr} !== {eh, ef, ep}) begin
      bad++;
      $display("FAIL %s addr=%h u=%0b w=%0b act hit=%0b flt=%0b pa=%h exp hit=%0b flt=%0b pa=%h",
               r, a, user, wr, lk_hit, lk_fault, lk_paddr, eh, ef, ep);
    end
  endtask

  task automatic chk(input string r, input logic [31:0] a, input bit user, input bit wr);
    @(negedge clk);
    look(r, a, user, wr, 0, 0);
  endtask

  task automatic mfill(input logic [19:0] v, input logic [19:0] p,
                       input bit w, input bit u, input bit d, input bit g);
    int s = -1;
    for (int j = 0; j < 8; j++) if (m_v[j] && m_vpn[j] == v) s = j;
    if (s < 0) for (int j = 7; j >= 0; j--) if (!m_v[j]) s = j;
    if (s < 0) begin s = m_ptr; m_ptr = (m_ptr + 1) % 8; end
    m_v[s] = 1; m_vpn[s] = v; m_pfn[s] = p;
    m_rw[s] = w; m_us[s] = u; m_d[s] = d; m_g[s] = g;
  endtask

  task automatic drive_fill(input logic [19:0] v, input logic [19:0] p,
                            input bit w, input bit u, input bit d, input bit g);
    fill_vpn = v; fill_pfn = p; fill_rw = w; fill_us = u;
    fill_dirty = d; fill_global = g; fill_en = 1;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input bit w, input bit u, input bit d, input bit g);
    @(negedge clk);
    drive_fill(v, p, w, u, d, g);
    @(posedge clk); #1 fill_en = 0;
    mfill(v, p, w, u, d, g);
  endtask

  task automatic sweep(input string r);
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 4; k++)
        chk(r, {m_vpn[j], 12'h050 + 12'(j * 12'h1f3)}, k[1], k[0]);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] va, vb, vc, vd, ve;
    va = 20'h7A000; vb = 20'h7B111; vc = 20'h7C222; vd = 20'h7D333; ve = 20'h7E444;
    for (int j = 0; j < 8; j++) begin m_v[j] = 0; m_vpn[j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10", 32'h0000_0000, 0, 0);
    chk("R10", 32'h0100_0123, 1, 1);

    // R2: same-cycle fill not yet visible, visible after edge
    @(negedge clk);
    drive_fill(20'h01000, 20'h0C000, 0, 0, 0, 0);
    look("R2", {20'h01000, 12'h050}, 0, 0, 0, 0);
    @(posedge clk); #1 fill_en = 0;
    mfill(20'h01000, 20'h0C000, 0, 0, 0, 0);
    chk("R2", {20'h01000, 12'h050}, 0, 0);

    for (int i = 1; i < 8; i++)
      fill(20'h01000 + 20'(i * 20'h00111), 20'h0C000 + 20'(i * 7),
           i[0], i[1], i[2], i[0] ^ i[2]);
    // R1 R4 R5 R6 over every slot and access kind
    sweep("R1/R4/R5/R6");

    // R3: eviction order and overwrite
    fill(va, 20'hA0001, 1, 1, 1, 0);
    chk("R3", {20'h01000, 12'h111}, 0, 0);
    chk("R3", {va, 12'hFFF}, 1, 1);
    fill(m_vpn[3], 20'hB3333, 1, 1, 1, 1);
    chk("R3", {m_vpn[3], 12'h004}, 1, 1);
    fill(vb, 20'hB0002, 0, 1, 0, 1);
    chk("R3", {20'h01111, 12'h222}, 0, 0);
    chk("R3", {m_vpn[2], 12'h333}, 0, 0);

    // R9: single-page invalidate
    @(negedge clk);
    inval_vpn = m_vpn[4]; inval_en = 1;
    @(posedge clk); #1 inval_en = 0;
    m_v[4] = 0;
    chk("R9", {m_vpn[4], 12'h444}, 0, 0);
    chk("R9", {m_vpn[5], 12'h555}, 0, 0);
    fill(vc, 20'hC0003, 1, 1, 0, 0);
    fill(vd, 20'hD0004, 1, 0, 1, 0);
    chk("R3", {vc, 12'h010}, 0, 0);
    chk("R3", {20'h01222, 12'h010}, 0, 0);
    sweep("R3");

    // R7: directory base write
    @(negedge clk);
    base_wr = 1;
    drive_fill(ve, 20'hE0005, 1, 1, 1, 1);
    look("R7", {va, 12'h100}, 0, 0, 1, 0);
    look("R7", {m_vpn[6], 12'h200}, 0, 0, 1, 0);
    look("R7", {m_vpn[3], 12'h300}, 1, 1, 1, 0);
    @(posedge clk); #1 base_wr = 0; fill_en = 0;
    for (int j = 0; j < 8; j++) if (!m_g[j]) m_v[j] = 0;
    sweep("R7");
    chk("R7", {ve, 12'h000}, 0, 0);

    // R8: full flush
    @(negedge clk);
    flush_all = 1;
    drive_fill(ve, 20'hE0005, 1, 1, 1, 1);
    look("R8", {m_vpn[3], 12'h0AB}, 0, 0, 0, 1);
    look("R8", {vb, 12'h0CD}, 1, 0, 0, 1);
    @(posedge clk); #1 flush_all = 0; fill_en = 0;
    for (int j = 0; j < 8; j++) m_v[j] = 0;
    sweep("R8");
    chk("R8", {ve, 12'h000}, 0, 0);
    fill(ve, 20'hE0005, 1, 1, 1, 1);
    chk("R3", {ve, 12'h777}, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule